// File: doc/BRIEF.md
# Five-Phase Multicycle Processor Core

This block is a small register-based processor. Every instruction goes through the same five one-clock phases, in this order: instruction fetch, decode, operand fetch, execute and result store. A phase with nothing to do for the current instruction still uses its clock. The core has a program counter, an instruction register, four general registers and an incrementing ALU. A single memory port carries both instruction fetches and data accesses. Reads on that port are combinational, and a write is committed at the clock edge that ends the cycle in which the write strobe is high.

The memory is outside the core, and the environment fills it with program and data before reset is released. Once reset is released, the core fetches from a start address set by a parameter. Execution stops at a halt instruction, which raises a done flag that stays high. The instruction set has four opcodes: load a register from memory, write one register's value plus one into another register, store a register to memory, and halt. Every other opcode does nothing and still takes the full five phases.

Top module: `multicycleCore`

## Requirements
- R1: During and right after a synchronous active-high reset, the core drives the start address (default 100) on `memAddr`, keeps `memWe` and `done` low, and clears all four registers to zero.
- R2: Each non-halt instruction takes exactly five cycles. Counting from the first cycle after reset, instruction k is fetched in cycle 5k from address START+k, so the program counter advances by one per instruction.
- R3: Instruction word layout: bits [15:12] are the opcode, bits [11:10] the register, bits [9:0] the address. A load (opcode 1) presents its address on `memAddr` in the third phase (cycle 5k+2) and writes the word it reads into the selected register.
- R4: An increment (opcode 2) writes the source register plus one into the register in bits [11:10] during the fourth phase. The source register number is held in bits [1:0]. The sum wraps modulo 2^16, so 0xFFFF becomes 0.
- R5: A store (opcode 3) raises `memWe` only in its fifth phase (cycle 5k+4), with the address field on `memAddr` and the selected register's value on `memWdata`.
- R6: `memWe` is never high outside the fifth phase of a store.
- R7: A halt (opcode 15) at instruction index h raises `done` in cycle 5h+2. After that `done` stays high, and there are no more writes.
- R8: Any other opcode changes no register and writes no memory, and the next instruction is still fetched five cycles later.
- R9: A three-instruction program at addresses 100 to 102 (load R0 from 500, increment R1 from R0, store R1 to 501) leaves 11 at address 501 when 10 was preloaded at 500.
- R10: An increment whose source and destination are the same register accumulates, so two increments in a row of R3 raise it by two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| memAddr | output | 10 | Memory word address: the program counter in fetch, otherwise the address field |
| memWe | output | 1 | Memory write strobe, committed at the clock edge |
| memWdata | output | 16 | Write data, the selected register |
| memRdata | input | 16 | Read data for memAddr, combinational |
| done | output | 1 | High from the cycle after a halt is decoded |

## Verification
The core runs five short programs, each chosen to separate one kind of fault from the others. The reference program checks load, increment and store together. A second program loads 0xFFFF and then increments it, which shows whether the ALU wraps. It also places an undefined opcode just before a store to an address, so a no-op that writes to memory would be caught. Repeated same-register increments, followed by a store of the untouched load register, show whether the register index selects the right register. Two more programs, one starting with a halt and one mixing load and store with an undefined opcode, check how the cycle budget is counted and that the core stays quiet after halting. Every memory write is compared against an expected queue for its exact cycle, address and value, and every fetch is compared against its expected cycle and address.

// File: rtl/coreTypesPkg.sv
package coreTypesPkg;
  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OP_LOAD  = 4'h1;
  localparam logic [OPC_W-1:0] OP_INC   = 4'h2;
  localparam logic [OPC_W-1:0] OP_STORE = 4'h3;
  localparam logic [OPC_W-1:0] OP_HALT  = 4'hF;

  typedef enum logic [2:0] {
    PH_FETCH,
    PH_DECODE,
    PH_OPERAND,
    PH_EXECUTE,
    PH_WRITEBACK,
    PH_HALTED
  } phase_t;

  typedef struct packed {
    logic loadIr;
    logic advancePc;
    logic addrFromPc;
    logic regFromMem;
    logic regFromAlu;
    logic memWrite;
  } strobes_t;
endpackage

// File: rtl/incAlu.sv
module incAlu #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] operand,
  output logic [WIDTH-1:0] result
);
  assign result = operand + WIDTH'(1);
endmodule

// File: rtl/seqControl.sv
module seqControl
  import coreTypesPkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  output strobes_t         strobes,
  output logic             done
);
  phase_t phase, phaseNext;
  logic isLoad, isInc, isStore, isHalt;

  always_comb begin
    isLoad  = (opcode == OP_LOAD);
    isInc   = (opcode == OP_INC);
    isStore = (opcode == OP_STORE);
    isHalt  = (opcode == OP_HALT);
  end

  always_comb begin
    case (phase)
      PH_FETCH:     phaseNext = PH_DECODE;
      PH_DECODE:    phaseNext = isHalt ? PH_HALTED : PH_OPERAND;
      PH_OPERAND:   phaseNext = PH_EXECUTE;
      PH_EXECUTE:   phaseNext = PH_WRITEBACK;
      PH_WRITEBACK: phaseNext = PH_FETCH;
      default:      phaseNext = PH_HALTED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_FETCH;
    else     phase <= phaseNext;
  end

  always_comb begin
    strobes = '0;
    case (phase)
      PH_FETCH: begin
        strobes.loadIr     = 1'b1;
        strobes.advancePc  = 1'b1;
        strobes.addrFromPc = 1'b1;
      end
      PH_OPERAND:   strobes.regFromMem = isLoad;
      PH_EXECUTE:   strobes.regFromAlu = isInc;
      PH_WRITEBACK: strobes.memWrite   = isStore;
      default:      strobes = '0;
    endcase
  end

  assign done = (phase == PH_HALTED);
endmodule

// File: rtl/dataPath.sv
module dataPath
  import coreTypesPkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int REG_W      = 2,
  parameter int ADDR_W     = 10,
  parameter int START_ADDR = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  strobes_t          strobes,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [OPC_W-1:0]  opcode
);
  localparam int INSTR_W  = OPC_W + REG_W + ADDR_W;
  localparam int NUM_REGS = 2 ** REG_W;
  localparam logic [ADDR_W-1:0] START_PC = ADDR_W'(START_ADDR);

  logic [ADDR_W-1:0]  pc;
  logic [INSTR_W-1:0] ir;
  logic [DATA_W-1:0]  regs [NUM_REGS];
  logic [REG_W-1:0]   regField, srcField;
  logic [ADDR_W-1:0]  addrField;
  logic [DATA_W-1:0]  aluOut;

  assign opcode    = ir[INSTR_W-1 -: OPC_W];
  assign regField  = ir[ADDR_W +: REG_W];
  assign addrField = ir[ADDR_W-1:0];
  assign srcField  = ir[REG_W-1:0];

  incAlu #(.WIDTH(DATA_W)) alu (
    .operand(regs[srcField]),
    .result (aluOut)
  );

  assign memAddr  = strobes.addrFromPc ? pc : addrField;
  assign memWdata = regs[regField];

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= START_PC;
      ir <= '0;
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else begin
      if (strobes.loadIr)     ir <= memRdata[INSTR_W-1:0];
      if (strobes.advancePc)  pc <= pc + ADDR_W'(1);
      if (strobes.regFromMem) regs[regField] <= memRdata;
      if (strobes.regFromAlu) regs[regField] <= aluOut;
    end
  end
endmodule

// File: rtl/multicycleCore.sv
module multicycleCore
  import coreTypesPkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int REG_W      = 2,
  parameter int ADDR_W     = 10,
  parameter int START_ADDR = 100
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              done
);
  strobes_t         strobes;
  logic [OPC_W-1:0] opcode;

  seqControl ctrl (
    .clk    (clk),
    .rst    (rst),
    .opcode (opcode),
    .strobes(strobes),
    .done   (done)
  );

  dataPath #(
    .DATA_W    (DATA_W),
    .REG_W     (REG_W),
    .ADDR_W    (ADDR_W),
    .START_ADDR(START_ADDR)
  ) dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .memRdata(memRdata),
    .memAddr (memAddr),
    .memWdata(memWdata),
    .opcode  (opcode)
  );

  assign memWe = strobes.memWrite;
endmodule

// File: rtl/coreChecker.sv
module coreChecker #(
  parameter int ADDR_W     = 10,
  parameter int START_ADDR = 100
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memWe,
  input logic              done
);
  localparam logic [ADDR_W-1:0] START_PC = ADDR_W'(START_ADDR);

  logic [2:0]        slot;
  logic              haveFetch;
  logic [ADDR_W-1:0] lastFetch;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot      <= '0;
      haveFetch <= 1'b0;
      lastFetch <= '0;
    end else if (!done) begin
      slot <= (slot == 3'd4) ? 3'd0 : slot + 3'd1;
      if (slot == 3'd0) begin
        haveFetch <= 1'b1;
        lastFetch <= memAddr;
      end
    end
  end

  assert_first_fetch_R1: assert property (@(posedge clk) disable iff (rst)
    (slot == 3'd0 && !haveFetch) |-> memAddr == START_PC);

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
    (slot == 3'd0 && haveFetch && !done) |-> memAddr == lastFetch + ADDR_W'(1));

  assert_write_slot_R6: assert property (@(posedge clk) disable iff (rst)
    memWe |-> (slot == 3'd4 && !done));

  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> done);

  assert_done_timing_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> slot == 3'd2);

  assert_quiet_halt_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> !memWe);
endmodule

bind multicycleCore coreChecker #(
  .ADDR_W    (ADDR_W),
  .START_ADDR(START_ADDR)
) chk (
  .clk    (clk),
  .rst    (rst),
  .memAddr(memAddr),
  .memWe  (memWe),
  .done   (done)
);

// File: tb/multicycleCore_test.sv
`timescale 1ns/1ps
module multicycleCore_test;
  localparam int START = 100;

  typedef struct {
    int cyc;
    int addr;
    int data;
  } wrItem_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  memAddr;
  logic        memWe;
  logic [15:0] memWdata;
  logic [15:0] memRdata;
  logic        done;

  logic [15:0] mem [1024];
  wrItem_t     expQ [$];
  int          nChecks = 0;
  int          nFails  = 0;

  always #4 clk = ~clk;

  assign memRdata = mem[memAddr];

  multicycleCore uut (
    .clk     (clk),
    .rst     (rst),
    .memAddr (memAddr),
    .memWe   (memWe),
    .memWdata(memWdata),
    .memRdata(memRdata),
    .done    (done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] instr(input int op, input int rg, input int addr);
    return {op[3:0], rg[1:0], addr[9:0]};
  endfunction

  task automatic expectWrite(input int cyc, input int addr, input int data);
    wrItem_t it;
    it.cyc = cyc; it.addr = addr; it.data = data;
    expQ.push_back(it);
  endtask

  task automatic clearMem();
    for (int i = 0; i < 1024; i++) mem[i] = 16'h0;
  endtask

  // haltIdx: index of the halt instruction; loadCyc/loadAddr: one load to watch (-1 for none)
  task automatic runProgram(input int haltIdx, input int loadCyc, input int loadAddr,
                            input string wrReq);
    int doneCyc;
    wrItem_t it;
    doneCyc = 5 * haltIdx + 2;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    check(memAddr == START, "R1", "reset address", memAddr, START);
    check(memWe == 1'b0, "R1", "reset write strobe", memWe, 0);
    check(done == 1'b0, "R1", "reset done", done, 0);
    @(negedge clk);
    rst = 1'b0;
    for (int cyc = 0; cyc <= doneCyc + 20; cyc++) begin
      #1;
      // monitor: compare write events against the scoreboard queue
      if (memWe) begin
        if (expQ.size() == 0) begin
          check(1'b0, wrReq, "unexpected write at address", memAddr, -1);
        end else begin
          it = expQ.pop_front();
          check(cyc == it.cyc, "R5", "write cycle", cyc, it.cyc);
          check(memAddr == it.addr, "R5", "write address", memAddr, it.addr);
          check(memWdata == it.data[15:0], wrReq, "write data", memWdata, it.data);
        end
        mem[memAddr] = memWdata;
      end
      if (cyc % 5 == 0 && cyc / 5 <= haltIdx && cyc < doneCyc)
        check(memAddr == START + cyc / 5, "R2", "fetch address", memAddr, START + cyc / 5);
      if (cyc == loadCyc)
        check(memAddr == loadAddr, "R3", "load operand address", memAddr, loadAddr);
      if (cyc == doneCyc - 1 || cyc == doneCyc || cyc == doneCyc + 20)
        check(done == (cyc >= doneCyc), "R7", "done level", done, cyc >= doneCyc);
      @(negedge clk);
    end
    check(expQ.size() == 0, "R5", "pending expected writes", expQ.size(), 0);
    expQ.delete();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    // Program A: reference program (R9, R3, R4, R5)
    clearMem();
    mem[100] = instr(1, 0, 500);
    mem[101] = instr(2, 1, 0);
    mem[102] = instr(3, 1, 501);
    mem[103] = instr(15, 0, 0);
    mem[500] = 16'd10;
    expectWrite(14, 501, 11);
    runProgram(3, 2, 500, "R9");
    check(mem[501] == 16'd11, "R9", "result at 501", mem[501], 11);
    check(mem[500] == 16'd10, "R9", "source at 500", mem[500], 10);

    // Program B: wrap, undefined opcode, same-register increment (R4, R8, R10)
    clearMem();
    mem[100] = instr(1, 2, 200);
    mem[101] = instr(2, 3, 2);
    mem[102] = instr(7, 3, 301);
    mem[103] = instr(3, 3, 300);
    mem[104] = instr(2, 3, 3);
    mem[105] = instr(2, 3, 3);
    mem[106] = instr(3, 3, 302);
    mem[107] = instr(3, 2, 303);
    mem[108] = instr(15, 0, 0);
    mem[200] = 16'hFFFF;
    mem[300] = 16'hAAAA;
    mem[301] = 16'h5555;
    expectWrite(19, 300, 0);
    expectWrite(34, 302, 2);
    expectWrite(39, 303, 16'hFFFF);
    runProgram(8, 2, 200, "R8");
    check(mem[300] == 16'h0, "R4", "wrapped increment", mem[300], 0);
    check(mem[301] == 16'h5555, "R8", "undefined opcode left memory", mem[301], 16'h5555);
    check(mem[302] == 16'd2, "R10", "same-register increments", mem[302], 2);
    check(mem[303] == 16'hFFFF, "R8", "load register untouched", mem[303], 16'hFFFF);

    // Program C: load/store with opcode 0 between (R3, R5, R8)
    clearMem();
    mem[100] = instr(1, 1, 400);
    mem[101] = instr(0, 1, 401);
    mem[102] = instr(3, 1, 401);
    mem[103] = instr(15, 0, 0);
    mem[400] = 16'h1234;
    expectWrite(14, 401, 16'h1234);
    runProgram(3, 2, 400, "R8");
    check(mem[401] == 16'h1234, "R5", "stored load value", mem[401], 16'h1234);

    // Program D: halt first (R7, R6)
    clearMem();
    mem[100] = instr(15, 0, 0);
    mem[101] = instr(3, 0, 50);
    mem[50]  = 16'h7777;
    runProgram(0, -1, 0, "R6");
    check(mem[50] == 16'h7777, "R7", "no store after halt", mem[50], 16'h7777);

    // Program E: store of a cleared register right after reset (R1)
    clearMem();
    mem[100] = instr(3, 2, 60);
    mem[101] = instr(15, 0, 0);
    mem[60]  = 16'hBEEF;
    expectWrite(4, 60, 0);
    runProgram(1, -1, 0, "R1");
    check(mem[60] == 16'h0, "R1", "register cleared by reset", mem[60], 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule